// File: doc/BRIEF.md
# Byte-Granular ECC Memory Controller

This controller connects a processor request port to a single-port array of 72-bit words, each holding 64 data bits and 8 check bits of a single-error-correcting, double-error-detecting Hamming code. Requests move 1, 2, 4 or 8 bytes. A full 8-byte write is encoded and stored in the cycle it is accepted. A narrower write fetches the stored word, repairs any single-bit fault, replaces the addressed bytes, encodes the result again and stores the whole word. Every word in the array therefore carries check bits that match its 64 data bits.

After reset the controller visits every word address once and stores the encoded value of zero. Only then does it accept requests, so no later fetch meets random check bits. Reads return the addressed field right-aligned, together with a one-cycle valid pulse. A fault that cannot be corrected raises a one-cycle flag. On a narrow write that flag also cancels the store. A saturating counter records how many single-bit faults have been corrected.

The array sits outside the block and is reached through a synchronous memory port with one cycle of read latency. This lets a test environment change stored bits directly.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: While reset is held, `req_ready`, `rd_valid` and `ue_flag` are 0 and `corr_count` is 0. After reset is released, the controller writes the encoding of zero to each word address from 0 to 2^ADDR_W-1, one per cycle. `req_ready` rises on the 2^ADDR_W-th clock edge after release and not before. From then on, every word reads as zero with no error flag.
- R2: A write with size code 11 is stored with `mem_en` and `mem_we` high in the same cycle it is accepted, with no read. `req_ready` stays high in the following cycle.
- R3: The size codes 00, 01, 10 and 11 select 1, 2, 4 and 8 bytes. `req_addr[2:0]` is the byte offset, and offset bits below the size's natural alignment are ignored. Write data is taken from the low bytes of `req_wdata`. Read data is returned in the low bytes of `rd_data`, with the upper bytes zero.
- R4: A write of fewer than 8 bytes changes only the addressed bytes and leaves the other bytes of the word unchanged. `req_ready` is low for the two cycles after acceptance.
- R5: A read produces a one-cycle `rd_valid` pulse. `rd_data` is valid on the third rising edge after the acceptance edge.
- R6: A read whose stored word has any one of its 72 bits flipped returns the correct data with `ue_flag` low.
- R7: A narrow write to a word with one flipped bit merges into the corrected data and stores a clean word. A later read of that word returns the merged data and does not count a correction.
- R8: A read whose stored word has two flipped bits raises `ue_flag` in the same cycle as `rd_valid`.
- R9: A narrow write whose fetched word has two flipped bits raises `ue_flag` for one cycle with `rd_valid` low and does not write the array. The stored word stays unchanged.
- R10: `corr_count` increases by one for every read or narrow write that corrects a single-bit fault. It holds at 2^CNT_W-1 and is cleared by reset.
- R11: The word address is `req_addr[ADDR_W+2:3]`. An access changes no other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | ADDR_W+3 | Byte address |
| req_wdata | input | 64 | Write data, right-aligned |
| rd_valid | output | 1 | One-cycle read response pulse |
| rd_data | output | 64 | Read field, right-aligned |
| ue_flag | output | 1 | One-cycle uncorrectable-fault pulse |
| corr_count | output | CNT_W | Saturating count of corrected faults |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | 72 | Encoded word to store |
| mem_rdata | input | 72 | Stored word, valid one cycle after a read access |

## Verification
The assertions assume the array behaves as a synchronous memory. A read access must return its word in the following cycle. The assertions also assume that `mem_rdata` changes only because of accesses or deliberate fault injection made while the controller is idle. The bench keeps to this by injecting faults only when `req_valid` is low and `req_ready` is high. It removes a fault left behind by a read before the next request, so that random traffic never builds up two faults in one word unless a case asks for it. Requests are presented only while `req_ready` is high and are held for exactly one accepting edge.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    localparam int DATA_W = 64;
    localparam int CODE_W = 72;
    localparam int LANES  = DATA_W / 8;
    localparam int SYN_W  = 7;
    localparam int OFF_W  = 3;

    typedef enum logic [1:0] {
        ST_SWEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FETCH = 2'd2,
        ST_APPLY = 2'd3
    } ctl_state_e;

    localparam logic [1:0] SZ_FULL = 2'b11;

    // Position p (1..71) is a check position when p is a power of two.
    function automatic logic is_check_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Codeword layout: bit 0 holds overall parity, bits 1..71 form a
    // Hamming code with check bits at power-of-two positions.
    function automatic logic [CODE_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < SYN_W; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> b) & 1) == 1) x = x ^ c[p];
            end
            c[1 << b] = x;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] secded_extract(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_rmw_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb code_out = secded_encode(data_in);
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_rmw_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              single_fix,
    output logic              double_det
);
    logic [SYN_W-1:0]  syndrome;
    logic              par_odd;
    logic [CODE_W-1:0] repaired;

    always_comb begin
        syndrome = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (code_in[p]) syndrome = syndrome ^ SYN_W'(p);
        end
        par_odd    = ^code_in;
        repaired   = code_in;
        single_fix = 1'b0;
        double_det = 1'b0;
        if (par_odd) begin
            if (syndrome == '0) begin
                repaired[0] = ~code_in[0];
                single_fix  = 1'b1;
            end else if (int'(syndrome) < CODE_W) begin
                repaired[syndrome] = ~code_in[syndrome];
                single_fix         = 1'b1;
            end else begin
                double_det = 1'b1;
            end
        end else if (syndrome != '0) begin
            double_det = 1'b1;
        end
        data_out = secded_extract(repaired);
    end
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
    import ecc_rmw_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offs,
    input  logic [DATA_W-1:0] new_field,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rd_field
);
    logic [DATA_W-1:0] field_mask;
    logic [OFF_W-1:0]  align_mask;
    logic [OFF_W:0]    nbytes;
    logic [OFF_W-1:0]  base;
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  lane_en;

    always_comb begin
        case (size)
            2'b00:   begin field_mask = 64'h0000_0000_0000_00FF; align_mask = 3'b111; nbytes = 4'd1; end
            2'b01:   begin field_mask = 64'h0000_0000_0000_FFFF; align_mask = 3'b110; nbytes = 4'd2; end
            2'b10:   begin field_mask = 64'h0000_0000_FFFF_FFFF; align_mask = 3'b100; nbytes = 4'd4; end
            default: begin field_mask = '1;                      align_mask = 3'b000; nbytes = 4'd8; end
        endcase
        base     = offs & align_mask;
        shifted  = (new_field & field_mask) << {base, 3'b000};
        rd_field = (old_word >> {base, 3'b000}) & field_mask;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (OFF_W'(i) >= base) &&
                            ({1'b0, OFF_W'(i)} < ({1'b0, base} + nbytes));
        assign merged[8*i +: 8] = lane_en[i] ? shifted[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W+2:0]     req_addr,
    input  logic [63:0]           req_wdata,
    output logic                  rd_valid,
    output logic [63:0]           rd_data,
    output logic                  ue_flag,
    output logic [CNT_W-1:0]      corr_count,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [71:0]           mem_wdata,
    input  logic [71:0]           mem_rdata
);
    localparam int BA_W = ADDR_W + OFF_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

    typedef struct packed {
        ctl_state_e          st;
        logic [ADDR_W-1:0]   sweep_addr;
        logic [CODE_W-1:0]   fetched;
        logic                wr;
        logic [1:0]          size;
        logic [OFF_W-1:0]    offs;
        logic [ADDR_W-1:0]   waddr;
        logic [DATA_W-1:0]   wdata;
        logic                rsp;
        logic [DATA_W-1:0]   rdata;
        logic                ue;
        logic [CNT_W-1:0]    cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DATA_W-1:0] enc_in;
    logic [CODE_W-1:0] enc_out;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [DATA_W-1:0] merged_word;
    logic [DATA_W-1:0] read_field;

    ecc_secded_enc i_enc (
        .data_in  (enc_in),
        .code_out (enc_out)
    );

    ecc_secded_dec i_dec (
        .code_in    (ctl_q.fetched),
        .data_out   (dec_data),
        .single_fix (dec_single),
        .double_det (dec_double)
    );

    ecc_lane_merge i_merge (
        .size      (ctl_q.size),
        .offs      (ctl_q.offs),
        .new_field (ctl_q.wdata),
        .old_word  (dec_data),
        .merged    (merged_word),
        .rd_field  (read_field)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rsp = 1'b0;
        ctl_d.ue  = 1'b0;
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctl_q.waddr;
        enc_in    = '0;

        case (ctl_q.st)
            ST_SWEEP: begin
                mem_en           = 1'b1;
                mem_we           = 1'b1;
                mem_addr         = ctl_q.sweep_addr;
                enc_in           = '0;
                ctl_d.sweep_addr = ctl_q.sweep_addr + 1'b1;
                if (ctl_q.sweep_addr == LAST_ADDR) ctl_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_addr  = req_addr[BA_W-1:OFF_W];
                if (req_valid) begin
                    if (req_write && req_size == SZ_FULL) begin
                        mem_en = 1'b1;
                        mem_we = 1'b1;
                        enc_in = req_wdata;
                    end else begin
                        mem_en      = 1'b1;
                        ctl_d.wr    = req_write;
                        ctl_d.size  = req_size;
                        ctl_d.offs  = req_addr[OFF_W-1:0];
                        ctl_d.waddr = req_addr[BA_W-1:OFF_W];
                        ctl_d.wdata = req_wdata;
                        ctl_d.st    = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                ctl_d.fetched = mem_rdata;
                ctl_d.st      = ST_APPLY;
            end
            default: begin
                if (dec_single && ctl_q.cnt != CNT_MAX) ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (!ctl_q.wr) begin
                    ctl_d.rsp   = 1'b1;
                    ctl_d.rdata = read_field;
                    ctl_d.ue    = dec_double;
                end else if (dec_double) begin
                    ctl_d.ue = 1'b1;
                end else begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                    enc_in = merged_word;
                end
                ctl_d.st = ST_IDLE;
            end
        endcase
        mem_wdata = enc_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_SWEEP;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_valid   = ctl_q.rsp;
    assign rd_data    = ctl_q.rdata;
    assign ue_flag    = ctl_q.ue;
    assign corr_count = ctl_q.cnt;
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic             rd_valid,
    input logic             ue_flag,
    input logic [CNT_W-1:0] corr_count,
    input logic             mem_en,
    input logic             mem_we
);
    localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

    logic [ADDR_W:0] stores_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) stores_seen <= '0;
        else if (mem_en && mem_we && stores_seen != DEPTH) stores_seen <= stores_seen + 1'b1;
    end

    a_r1_ready_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> stores_seen == DEPTH);

    a_r2_full_write_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size == 2'b11) |-> (mem_en && mem_we));

    a_r4_busy_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_write && req_size == 2'b11)) |=> !req_ready);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r9_abort_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !rd_valid) |-> !$past(mem_we));

    a_r10_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_count) |-> corr_count == CNT_W'($past(corr_count) + 1'b1));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (&corr_count) |=> (&corr_count));
endmodule

bind ecc_rmw_ctrl ecc_rmw_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_size   (req_size),
    .rd_valid   (rd_valid),
    .ue_flag    (ue_flag),
    .corr_count (corr_count),
    .mem_en     (mem_en),
    .mem_we     (mem_we)
);

// File: tb/test_ecc_rmw_ctrl.sv
module test_ecc_rmw_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int CW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int BA    = AW + 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [BA-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic          ue_flag;
    logic [CW-1:0] corr_count;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;
    logic [71:0]   mem_rdata;

    logic [71:0]   ram [DEPTH];
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [71:0]   inj_mask = '0;
    logic          scramble = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0] shadow [DEPTH];
    int          exp_cnt = 0;
    bit          last_direct;
    bit          last_ready_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_rmw_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_ecc_rmw_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ue_flag(ue_flag), .corr_count(corr_count), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (scramble) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= 72'({$urandom, $urandom, $urandom});
        end else if (inj_en) begin
            ram[inj_addr] <= ram[inj_addr] ^ inj_mask;
        end else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] aligned_base(input logic [1:0] sz, input logic [2:0] off);
        int n;
        n = 1 << sz;
        return 3'((int'(off) / n) * n);
    endfunction

    function automatic logic [63:0] model_merge(input logic [63:0] old, input logic [1:0] sz,
                                                input logic [2:0] off, input logic [63:0] wd);
        logic [63:0] r;
        int b;
        r = old;
        b = int'(aligned_base(sz, off));
        for (int j = 0; j < (1 << sz); j++) r[8*(b+j) +: 8] = wd[8*j +: 8];
        return r;
    endfunction

    function automatic logic [63:0] model_field(input logic [63:0] w, input logic [1:0] sz,
                                                input logic [2:0] off);
        logic [63:0] r;
        int b;
        r = '0;
        b = int'(aligned_base(sz, off));
        for (int j = 0; j < (1 << sz); j++) r[8*j +: 8] = w[8*(b+j) +: 8];
        return r;
    endfunction

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [BA-1:0] a,
                         input logic [63:0] wd, output logic [63:0] rdo,
                         output bit ueo, output int lat);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = a;
        req_wdata = wd;
        #1;
        last_direct = mem_en && mem_we;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        last_ready_after = req_ready;
        rdo = '0;
        ueo = 1'b0;
        lat = 0;
        if (!(wr && sz == 2'b11)) begin
            lat = 1;
            while (!(rd_valid || ue_flag || (wr && req_ready)) && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            rdo = rd_data;
            ueo = ue_flag;
        end
    endtask

    task automatic inject(input int w, input logic [71:0] m);
        @(negedge clk);
        inj_addr = AW'(w);
        inj_mask = m;
        inj_en   = 1'b1;
        @(negedge clk);
        inj_en   = 1'b0;
    endtask

    function automatic logic [BA-1:0] baddr(input int w, input int off);
        return BA'(w * 8 + off);
    endfunction

    logic [63:0] rv;
    bit          ue;
    int          lat;
    logic [71:0] snap;

    initial begin
        void'($urandom(32'h1c3a_5e07));
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;

        // R1: reset state, array filled with garbage first
        scramble = 1'b1;
        repeat (2) @(negedge clk);
        scramble = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, "R1", "ready in reset", 72'(req_ready), 72'd0);
        check(rd_valid == 1'b0 && ue_flag == 1'b0, "R1", "pulses in reset",
              72'({rd_valid, ue_flag}), 72'd0);
        check(corr_count == '0, "R10", "count cleared by reset", 72'(corr_count), 72'd0);
        rst_n = 1'b1;
        begin
            int n;
            n = 0;
            while (!req_ready && n < 10 * DEPTH) begin
                @(negedge clk);
                n++;
            end
            check(n == DEPTH, "R1", "sweep length", 72'(n), 72'(DEPTH));
        end

        // R1: every word reads zero with no error after the sweep
        begin
            bit all_ok;
            all_ok = 1'b1;
            for (int w = 0; w < DEPTH; w++) begin
                issue(1'b0, 2'b11, baddr(w, 0), '0, rv, ue, lat);
                if (rv != '0 || ue) all_ok = 1'b0;
            end
            check(all_ok, "R1", "swept words read zero", 72'(all_ok), 72'd1);
        end

        // R2: direct full write
        issue(1'b1, 2'b11, baddr(3, 0), 64'h0123_4567_89AB_CDEF, rv, ue, lat);
        shadow[3] = 64'h0123_4567_89AB_CDEF;
        check(last_direct, "R2", "store in accept cycle", 72'(last_direct), 72'd1);
        check(last_ready_after, "R2", "ready stays high", 72'(last_ready_after), 72'd1);

        // R5: read latency and R11 addressing
        issue(1'b0, 2'b11, baddr(3, 0), '0, rv, ue, lat);
        check(lat == 3, "R5", "read latency", 72'(lat), 72'd3);
        check(rv == shadow[3], "R11", "word readback", 72'(rv), 72'(shadow[3]));
        @(negedge clk);
        check(rd_valid == 1'b0, "R5", "valid one cycle", 72'(rd_valid), 72'd0);
        issue(1'b0, 2'b11, baddr(2, 0), '0, rv, ue, lat);
        check(rv == '0, "R11", "neighbour untouched", 72'(rv), 72'd0);

        // R4: byte write at offset 5
        issue(1'b1, 2'b00, baddr(3, 5), 64'hFFFF_FFFF_FFFF_FF5A, rv, ue, lat);
        check(!last_ready_after, "R4", "ready low after accept", 72'(last_ready_after), 72'd0);
        shadow[3] = model_merge(shadow[3], 2'b00, 3'd5, 64'h5A);
        issue(1'b0, 2'b11, baddr(3, 0), '0, rv, ue, lat);
        check(rv == shadow[3], "R4", "byte merge", 72'(rv), 72'(shadow[3]));

        // R3: misaligned half and word writes are aligned down
        issue(1'b1, 2'b01, baddr(3, 3), 64'h0000_0000_0000_BEEF, rv, ue, lat);
        shadow[3] = model_merge(shadow[3], 2'b01, 3'd2, 64'hBEEF);
        issue(1'b1, 2'b10, baddr(3, 6), 64'h0000_0000_CAFE_F00D, rv, ue, lat);
        shadow[3] = model_merge(shadow[3], 2'b10, 3'd4, 64'hCAFE_F00D);
        issue(1'b0, 2'b11, baddr(3, 0), '0, rv, ue, lat);
        check(rv == shadow[3], "R3", "aligned-down merges", 72'(rv), 72'(shadow[3]));
        issue(1'b0, 2'b00, baddr(3, 7), '0, rv, ue, lat);
        check(rv == model_field(shadow[3], 2'b00, 3'd7), "R3", "byte read right-aligned",
              72'(rv), 72'(model_field(shadow[3], 2'b00, 3'd7)));
        issue(1'b0, 2'b01, baddr(3, 5), '0, rv, ue, lat);
        check(rv == model_field(shadow[3], 2'b01, 3'd4), "R3", "half read aligned",
              72'(rv), 72'(model_field(shadow[3], 2'b01, 3'd4)));

        // R7: single fault corrected before merge, stored clean
        issue(1'b1, 2'b11, baddr(6, 0), 64'hA5A5_5A5A_F0F0_0F0F, rv, ue, lat);
        shadow[6] = 64'hA5A5_5A5A_F0F0_0F0F;
        inject(6, 72'd1 << 40);
        issue(1'b1, 2'b00, baddr(6, 1), 64'h77, rv, ue, lat);
        shadow[6] = model_merge(shadow[6], 2'b00, 3'd1, 64'h77);
        exp_cnt++;
        check(!ue, "R7", "no flag on corrected merge", 72'(ue), 72'd0);
        check(int'(corr_count) == exp_cnt, "R10", "count after merge fix", 72'(corr_count), 72'(exp_cnt));
        issue(1'b0, 2'b11, baddr(6, 0), '0, rv, ue, lat);
        check(rv == shadow[6], "R7", "merged data stored", 72'(rv), 72'(shadow[6]));
        check(int'(corr_count) == exp_cnt, "R7", "stored word clean", 72'(corr_count), 72'(exp_cnt));

        // R6 / R10: every single bit position corrected, counter saturates
        issue(1'b1, 2'b11, baddr(5, 0), 64'h1357_9BDF_2468_ACE0, rv, ue, lat);
        shadow[5] = 64'h1357_9BDF_2468_ACE0;
        begin
            bit data_ok, cnt_ok;
            data_ok = 1'b1;
            cnt_ok  = 1'b1;
            for (int b = 0; b < 72; b++) begin
                inject(5, 72'd1 << b);
                issue(1'b0, 2'b11, baddr(5, 0), '0, rv, ue, lat);
                if (rv != shadow[5] || ue) data_ok = 1'b0;
                if (exp_cnt < CMAX) exp_cnt++;
                if (int'(corr_count) != exp_cnt) cnt_ok = 1'b0;
                inject(5, 72'd1 << b);
            end
            check(data_ok, "R6", "all 72 single faults corrected", 72'(data_ok), 72'd1);
            check(cnt_ok, "R10", "count tracks and saturates", 72'(cnt_ok), 72'd1);
            check(int'(corr_count) == CMAX, "R10", "count at max", 72'(corr_count), 72'(CMAX));
        end

        // R8: double fault on read
        issue(1'b1, 2'b11, baddr(7, 0), 64'h0F0F_0F0F_0F0F_0F0F, rv, ue, lat);
        shadow[7] = 64'h0F0F_0F0F_0F0F_0F0F;
        inject(7, (72'd1 << 3) | (72'd1 << 50));
        issue(1'b0, 2'b11, baddr(7, 0), '0, rv, ue, lat);
        check(ue && rd_valid, "R8", "flag with read valid", 72'({ue, rd_valid}), 72'd3);
        issue(1'b1, 2'b11, baddr(7, 0), shadow[7], rv, ue, lat);

        // R9: double fault on narrow write aborts the store
        issue(1'b1, 2'b11, baddr(8, 0), 64'h8888_4444_2222_1111, rv, ue, lat);
        shadow[8] = 64'h8888_4444_2222_1111;
        inject(8, (72'd1 << 0) | (72'd1 << 71));
        snap = ram[8];
        issue(1'b1, 2'b00, baddr(8, 2), 64'h99, rv, ue, lat);
        check(ue, "R9", "flag on aborted write", 72'(ue), 72'd1);
        check(!rd_valid, "R9", "no read valid", 72'(rd_valid), 72'd0);
        @(negedge clk);
        check(ram[8] == snap, "R9", "stored word unchanged", ram[8], snap);
        issue(1'b1, 2'b11, baddr(8, 0), shadow[8], rv, ue, lat);

        // Random traffic with occasional single faults
        begin
            bit rnd_ok;
            rnd_ok = 1'b1;
            for (int n = 0; n < 400; n++) begin
                int w, off;
                bit wr, flt;
                logic [1:0] sz;
                logic [63:0] wd;
                int bitpos;
                w      = int'($urandom % DEPTH);
                off    = int'($urandom % 8);
                wr     = 1'($urandom % 2);
                sz     = 2'($urandom % 4);
                wd     = {$urandom, $urandom};
                flt    = ($urandom % 4) == 0 && !(wr && sz == 2'b11);
                bitpos = int'($urandom % 72);
                if (flt) inject(w, 72'd1 << bitpos);
                issue(wr, sz, baddr(w, off), wd, rv, ue, lat);
                if (flt && exp_cnt < CMAX) exp_cnt++;
                if (ue) rnd_ok = 1'b0;
                if (wr) begin
                    shadow[w] = model_merge(shadow[w], sz, 3'(off), wd);
                end else begin
                    if (rv != model_field(shadow[w], sz, 3'(off))) begin
                        rnd_ok = 1'b0;
                        $display("FAIL R3 random read w=%0d: actual=%h expected=%h",
                                 w, rv, model_field(shadow[w], sz, 3'(off)));
                    end
                    if (flt) inject(w, 72'd1 << bitpos);
                end
            end
            check(rnd_ok, "R4", "random traffic", 72'(rnd_ok), 72'd1);
            check(int'(corr_count) == exp_cnt, "R10", "count after random", 72'(corr_count), 72'(exp_cnt));
        end

        // R11: final sweep of all words against the model
        begin
            bit all_ok;
            all_ok = 1'b1;
            for (int w = 0; w < DEPTH; w++) begin
                issue(1'b0, 2'b11, baddr(w, 0), '0, rv, ue, lat);
                if (rv != shadow[w] || ue) all_ok = 1'b0;
            end
            check(all_ok, "R11", "final contents", 72'(all_ok), 72'd1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule